// File: doc/BRIEF.md
# Flow Tuple Hash Generator

This block turns a packet-flow key into a bucket index for a hashed flow table. Each request carries a flow-kind code, two 128-bit address fields and a 32-bit layer-4 port word. Depending on the kind, three 32-bit mixing words are taken from the key. For bridged flows they come from the MAC addresses. For IPv4 routed or translated flows they come from the ports and addresses. For IPv6 flows the 128-bit addresses are XOR-folded down. The three words then pass through a select, rotate, XOR and fold network, and the result is shifted up one place and trimmed to the table size.

The result appears in a register one clock after the request strobe, together with a one-cycle valid pulse and an error flag. Because the index is shifted, every legal result is even, so each hash names the first slot of a pair of adjacent entries. Flow kinds the network does not cover return the all-ones table mask with the error flag raised.

Top module: `flowhash_gen`

## Requirements
- R1: Kind code 2 (bridged) takes its words from the address fields. src_addr[31:0] is the source MAC high word and src_addr[47:32] is the 16-bit source MAC low part. dst_addr[31:0] and dst_addr[47:32] hold the destination MAC the same way. The words are w1 = srclo ^ (srchi[15:0] << 16), w2 = (srchi >> 16) ^ dstlo and w3 = dsthi.
- R2: Kind codes 0 (translated IPv4) and 1 (routed IPv4) use w1 = l4_ports, w2 = dst_addr[31:0] and w3 = src_addr[31:0].
- R3: Kind codes 4 and 5 (IPv6 three-tuple and five-tuple) use the 32-bit words S0..S3 of src_addr (Sk = src_addr[32k+31:32k]) and D0..D3 of dst_addr. The words are w1 = S3^D3^l4_ports, w2 = S2^D2^D0 and w3 = S1^D1^S0.
- R4: The mix computes m = (w1 & w2) | (~w1 & w3). It rotates m left by 8, XORs the result with w1, w2 and w3 to give x, and forms f = x ^ (x >> 16).
- R5: For a supported kind, out_idx equals (f << 1) truncated to IDX_W bits, so out_idx[0] is always 0.
- R6: Kind codes 3, 6 and 7 give out_idx = all ones (2^IDX_W - 1) with out_err = 1. Supported kinds give out_err = 0.
- R7: out_valid is high in exactly the cycle after each cycle with in_valid high, and back-to-back requests give back-to-back results.
- R8: Cycles without in_valid leave out_idx and out_err unchanged, whatever the other inputs do.
- R9: While rst_n is low, out_valid, out_idx and out_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 3 | Flow-kind code |
| src_addr | input | 128 | Source address words S0..S3 (MAC in the low 48 bits) |
| dst_addr | input | 128 | Destination address words D0..D3 (MAC in the low 48 bits) |
| l4_ports | input | 32 | Packed layer-4 port word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_idx | output | IDX_W | Bucket index |
| out_err | output | 1 | Unsupported flow kind |

## Verification
The bench aims at the fragile corners of the MAC word packing.
- Random high MAC halves catch a design that swaps the 16-bit halves or uses the wrong shift direction, because the index then changes.
- Directed keys with one non-zero word give hand-computed indices (2 and 0x202). A select with its operands reversed, or a rotate that goes the wrong way, moves those bits elsewhere.
- The three unsupported codes are checked against the all-ones mask. A design that forgets one of them returns an ordinary even index with no error.
- Idle cycles with changed inputs show whether the register loads without a strobe.
- Streams of back-to-back requests show whether a valid pulse is dropped or stretched.

// File: rtl/flowhash_pkg.sv
package flowhash_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned ADDR_W   = 4 * WORD_W;

   typedef enum logic [2:0] {
      FK_NAPT4   = 3'd0,
      FK_ROUTE4  = 3'd1,
      FK_BRIDGE  = 3'd2,
      FK_TUN4IN6 = 3'd3,
      FK_ROUTE6A = 3'd4,
      FK_ROUTE6B = 3'd5,
      FK_RSVD    = 3'd6,
      FK_TUN6IN4 = 3'd7
   } flow_kind_e;

   typedef struct packed {
      logic [WORD_W-1:0] w1;
      logic [WORD_W-1:0] w2;
      logic [WORD_W-1:0] w3;
   } mix_words_t;
endpackage

// File: rtl/flowhash_keysel.sv
module flowhash_keysel
   import flowhash_pkg::*;
(
   input  logic [2:0]        kind,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   input  logic [WORD_W-1:0] ports,
   output mix_words_t        words,
   output logic              unsup
);
   logic [WORD_W-1:0] s_w [4];
   logic [WORD_W-1:0] d_w [4];

   for (genvar k = 0; k < 4; k++) begin : g_split
      assign s_w[k] = src[WORD_W*k +: WORD_W];
      assign d_w[k] = dst[WORD_W*k +: WORD_W];
   end

   // bridged MAC halves
   logic [15:0]       smac_lo, dmac_lo;
   logic [WORD_W-1:0] smac_hi, dmac_hi;
   assign smac_hi = s_w[0];
   assign smac_lo = s_w[1][15:0];
   assign dmac_hi = d_w[0];
   assign dmac_lo = d_w[1][15:0];

   always_comb begin
      words = '0;
      unsup = 1'b0;
      case (flow_kind_e'(kind))
         FK_BRIDGE: begin
            words.w1 = {16'h0, smac_lo} ^ {smac_hi[15:0], 16'h0};
            words.w2 = {16'h0, smac_hi[31:16]} ^ {16'h0, dmac_lo};
            words.w3 = dmac_hi;
         end
         FK_NAPT4, FK_ROUTE4: begin
            words.w1 = ports;
            words.w2 = d_w[0];
            words.w3 = s_w[0];
         end
         FK_ROUTE6A, FK_ROUTE6B: begin
            words.w1 = s_w[3] ^ d_w[3] ^ ports;
            words.w2 = s_w[2] ^ d_w[2] ^ d_w[0];
            words.w3 = s_w[1] ^ d_w[1] ^ s_w[0];
         end
         default: unsup = 1'b1;
      endcase
   end
endmodule

// File: rtl/flowhash_mix.sv
module flowhash_mix
   import flowhash_pkg::*;
#(
   parameter int unsigned IDX_W = 14,
   parameter int unsigned ROT   = 8,
   parameter int unsigned FOLD  = 16
) (
   input  mix_words_t       words,
   input  logic             unsup,
   output logic [IDX_W-1:0] idx
);
   if (ROT < 1 || ROT > WORD_W - 1) begin : g_bad_rot
      $error("flowhash_mix: ROT out of range");
   end
   if (FOLD < 1 || FOLD > WORD_W - 1) begin : g_bad_fold
      $error("flowhash_mix: FOLD out of range");
   end

   logic [WORD_W-1:0] sel, rot, xsum, fold;

   // bitwise select: w2 where w1 is set, w3 elsewhere
   for (genvar b = 0; b < WORD_W; b++) begin : g_sel
      assign sel[b] = words.w1[b] ? words.w2[b] : words.w3[b];
   end

   assign rot  = (sel << ROT) | (sel >> (WORD_W - ROT));
   assign xsum = rot ^ words.w1 ^ words.w2 ^ words.w3;
   assign fold = xsum ^ (xsum >> FOLD);

   assign idx = unsup ? {IDX_W{1'b1}} : IDX_W'({fold, 1'b0});
endmodule

// File: rtl/flowhash_oreg.sv
module flowhash_oreg #(
   parameter int unsigned IDX_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             err_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         idx_o <= '0;
         err_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            idx_o <= idx_i;
            err_o <= err_i;
         end
      end
   end
endmodule

// File: rtl/flowhash_gen.sv
module flowhash_gen
   import flowhash_pkg::*;
#(
   parameter int unsigned IDX_W = 14,
   parameter int unsigned ROT   = 8,
   parameter int unsigned FOLD  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_kind,
   input  logic [127:0]     src_addr,
   input  logic [127:0]     dst_addr,
   input  logic [31:0]      l4_ports,
   output logic             out_valid,
   output logic [IDX_W-1:0] out_idx,
   output logic             out_err
);
   if (IDX_W < 2 || IDX_W > WORD_W) begin : g_bad_idx
      $error("flowhash_gen: IDX_W out of range");
   end

   mix_words_t       words;
   logic             unsup;
   logic [IDX_W-1:0] idx_c;

   flowhash_keysel u_sel (
      .kind  (in_kind),
      .src   (src_addr),
      .dst   (dst_addr),
      .ports (l4_ports),
      .words (words),
      .unsup (unsup)
   );

   flowhash_mix #(.IDX_W(IDX_W), .ROT(ROT), .FOLD(FOLD)) u_mix (
      .words (words),
      .unsup (unsup),
      .idx   (idx_c)
   );

   flowhash_oreg #(.IDX_W(IDX_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .idx_i (idx_c),
      .err_i (unsup),
      .vld_o (out_valid),
      .idx_o (out_idx),
      .err_o (out_err)
   );
endmodule

// File: rtl/flowhash_gen_chk.sv
module flowhash_gen_chk #(
   parameter int unsigned IDX_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       in_kind,
   input logic             out_valid,
   input logic [IDX_W-1:0] out_idx,
   input logic             out_err
);
   logic kind_bad;
   assign kind_bad = (in_kind == 3'd3) || (in_kind == 3'd6) || (in_kind == 3'd7);

   // R7
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R7
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R5
   even_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err) |-> !out_idx[0]);
   // R6
   err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_idx == {IDX_W{1'b1}}));
   // R6
   err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_err == $past(kind_bad)));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_idx) && $stable(out_err)));
endmodule

bind flowhash_gen flowhash_gen_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_kind   (in_kind),
   .out_valid (out_valid),
   .out_idx   (out_idx),
   .out_err   (out_err)
);

// File: tb/flowhash_gen_tb_top.sv
module flowhash_gen_tb_top;
   localparam int IW = 14;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [2:0]     in_kind = '0;
   logic [127:0]   src_addr = '0;
   logic [127:0]   dst_addr = '0;
   logic [31:0]    l4_ports = '0;
   logic           out_valid;
   logic [IW-1:0]  out_idx;
   logic           out_err;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   flowhash_gen #(.IDX_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .src_addr(src_addr), .dst_addr(dst_addr), .l4_ports(l4_ports),
      .out_valid(out_valid), .out_idx(out_idx), .out_err(out_err)
   );

   // returns {err, idx}
   function automatic logic [IW:0] model(input logic [2:0] k, input logic [127:0] s,
                                         input logic [127:0] d, input logic [31:0] p);
      logic [31:0] a, b, c, m, x, f;
      logic [31:0] S0, S1, S2, S3, D0, D1, D2, D3;
      S0 = s[31:0]; S1 = s[63:32]; S2 = s[95:64]; S3 = s[127:96];
      D0 = d[31:0]; D1 = d[63:32]; D2 = d[95:64]; D3 = d[127:96];
      case (k)
         3'd2: begin
            a = {16'h0, S1[15:0]} ^ {S0[15:0], 16'h0};
            b = (S0 >> 16) ^ {16'h0, D1[15:0]};
            c = D0;
         end
         3'd0, 3'd1: begin a = p; b = D0; c = S0; end
         3'd4, 3'd5: begin
            a = S3 ^ D3 ^ p; b = S2 ^ D2 ^ D0; c = S1 ^ D1 ^ S0;
         end
         default: return {1'b1, {IW{1'b1}}};
      endcase
      m = (a & b) | (~a & c);
      x = {m[23:0], m[31:24]} ^ a ^ b ^ c;
      f = x ^ (x >> 16);
      return {1'b0, f[IW-2:0], 1'b0};
   endfunction

   task automatic check(input string req, input logic [IW+1:0] act, input logic [IW+1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive a request at a negedge; result checked one clock later
   task automatic req(input string tag, input logic [2:0] k, input logic [127:0] s,
                      input logic [127:0] d, input logic [31:0] p);
      logic [IW:0] e;
      in_valid = 1'b1; in_kind = k; src_addr = s; dst_addr = d; l4_ports = p;
      e = model(k, s, d, p);
      @(negedge clk);
      check(tag, {out_valid, out_err, out_idx}, {1'b1, e});
   endtask

   task automatic idle();
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [IW-1:0] held;
      logic          held_e;
      void'($urandom(32'd4242));
      @(negedge clk);
      // R9 reset state
      check("R9", {out_valid, out_err, out_idx}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4/R5 hand-computed values
      req("R4", 3'd1, '0, '0, 32'h1);
      check("R4 literal", {2'b0, out_idx}, {2'b0, 14'h0002});
      req("R4", 3'd0, 128'h1, '0, 32'h0);
      check("R4 literal", {2'b0, out_idx}, {2'b0, 14'h0202});
      req("R5", 3'd1, {4{32'hFFFF_FFFF}}, {4{32'h1234_5678}}, 32'hA5A5_A506);
      check("R5 even", {{IW+1{1'b0}}, out_idx[0]}, '0);
      idle();
      // R7 pulse ends
      check("R7 pulse", {{IW+1{1'b0}}, out_valid}, '0);

      // R6 unsupported kinds
      req("R6", 3'd3, {4{32'hDEAD_BEEF}}, '1, 32'h5);
      req("R6", 3'd6, '0, '0, 32'h0);
      req("R6", 3'd7, {4{32'h0101_0101}}, '0, 32'h9);
      // R1 bridged with busy MAC halves
      req("R1", 3'd2, {96'h0, 32'hABCD_1234}, {96'h0, 32'h0000_0001}, 32'h0);
      req("R1", 3'd2, {80'hFFFF, 16'h5A5A, 32'h8000_FFFF}, {80'hFFFF, 16'hC3C3, 32'h1357_9BDF}, 32'hFFFF);
      // R3 IPv6 fold
      req("R3", 3'd4, 128'h0001_0002_0003_0004_0005_0006_0007_0008,
                      128'h1111_2222_3333_4444_5555_6666_7777_8888, 32'h0050_1F90);
      req("R3", 3'd5, {4{32'hF0F0_0F0F}}, {32'h0, 32'h0, 32'h0, 32'h1}, 32'h0);
      idle();

      // R8 hold across idle cycles with changed inputs
      held = out_idx; held_e = out_err;
      for (int i = 0; i < 4; i++) begin
         in_kind = 3'($urandom); src_addr = {4{$urandom}}; l4_ports = $urandom;
         @(negedge clk);
         check("R8 hold", {1'b0, out_err, out_idx}, {1'b0, held_e, held});
      end

      // random mix, bursts of back-to-back requests (R1 R2 R3 R6 R7)
      for (int n = 0; n < 600; n++) begin
         logic [2:0] k;
         k = 3'($urandom);
         req((k == 3'd2) ? "R1" : (k < 3'd2) ? "R2" : (k == 3'd4 || k == 3'd5) ? "R3" : "R6",
             k, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom}, $urandom);
         if ($urandom % 4 == 0) begin
            idle();
            check("R7 pulse", {{IW+1{1'b0}}, out_valid}, '0);
         end
      end
      idle();

      // R9 reset mid-run clears outputs
      req("R2", 3'd1, 128'h7, 128'h9, 32'h3);
      rst_n = 1'b0;
      #1;
      check("R9", {out_valid, out_err, out_idx}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule